// File: doc/BRIEF.md
# Always-On Millisecond Timer with Alarm

This block keeps a 64-bit millisecond count for a power domain that stays alive while the rest of the chip sleeps. Each millisecond step comes from a tick generator. The generator counts strobes from one of two reference oscillators through a fractional accumulator, or it follows the rising edges of an external 1 kHz pin. Software sets the reference rate as a whole number of kHz plus a 16-bit fraction of a kHz. A second external pin carrying 1 Hz can pull the count forward to the next whole second.

A 64-bit alarm comparator sets a sticky flag when the count equals a programmed time. The flag can be routed to an interrupt, to a power-up request, or to both. All access goes through a simple synchronous register port. Every write carries a 16-bit key in its upper half, and a write with a wrong key changes nothing.

Top module: `aon_ms_timer`

## Requirements
- R1: A write takes effect only when wr_data[31:16] equals the key 16'h5A3C. A write with any other key leaves every register, the count and the alarm flag unchanged.
- R2: Writes to addresses 2, 3, 4 and 5 load count bits 15:0, 31:16, 47:32 and 63:48 from wr_data[15:0]. A read of address 14 returns count bits 31:0 and a read of address 15 returns count bits 63:32. Read data appears on rd_data one cycle after rd_en. The two halves are read live, so a carry out of the low half shows up in the high half.
- R3: The reference rate is F = INT*65536 + FRAC, with INT at least 1. For the low-power oscillator, INT is at address 10 and FRAC at address 11. For the crystal oscillator, INT is at address 12 and FRAC at address 13. After N strobes of the selected oscillator, counted from a source switch, the count has advanced by floor(N*65536/F).
- R4: The control register is at address 0. Bits 6:5 select the tick source: 0 is the low-power oscillator, 1 is the crystal, 2 is the external 1 kHz pin and 3 is no source. Strobes and edges from sources that are not selected do not advance the count.
- R5: Control read bits 10:8 are the in-use flags for the low-power oscillator, the crystal and the external pin, in that order. At most one flag is set. All three read zero while a source change is in progress. After the change has settled, the flag of the requested source is set.
- R6: With the external pin selected, each rising edge of ext_khz_pin advances the count by one.
- R7: While control bit 0 (run) is clear, the count holds.
- R8: With control bit 4 set, a rising edge on ext_hz_pin rounds the count up to the next multiple of 1000 ms. The multiples are measured from the last count load or sync. If the count already sits on such a boundary, it does not change.
- R9: When control bit 1 (alarm enable) is set and the count equals the alarm time, control read bit 12 (alarm flag) becomes set. The flag stays set until a write of 1 to bit 0 of address 1.
- R10: Addresses 6 to 9 hold alarm bits 15:0, 31:16, 47:32 and 63:48, and they read back. Writes to them are ignored while alarm enable is set.
- R11: alarm_irq follows the alarm flag gated by control bit 2. pwrup_req follows the alarm flag gated by control bit 3.
- R12: After reset the count is 0, the control payload is 0, the low-power oscillator is requested, and alarm_irq and pwrup_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Key in bits 31:16, payload in bits 15:0 |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Registered read data |
| lp_ref_pulse | input | 1 | One-cycle strobe per low-power oscillator cycle |
| xo_ref_pulse | input | 1 | One-cycle strobe per crystal oscillator cycle |
| ext_khz_pin | input | 1 | External 1 kHz tick pin (asynchronous) |
| ext_hz_pin | input | 1 | External 1 Hz sync pin (asynchronous) |
| alarm_irq | output | 1 | Alarm interrupt |
| pwrup_req | output | 1 | Alarm power-up request |

## Verification
Assertions check four things on every cycle:
- A write with a wrong key leaves the configuration and alarm registers stable.
- The alarm registers stay stable while the alarm is armed.
- Without a load or a sync, the count moves by at most one per cycle.
- At most one in-use flag is set, the sub-second phase stays below 1000, and the alarm flag rises only on a cycle that follows an armed match.

The fractional tick rate can only be shown by the bench's scenarios. The bench sweeps integer and fraction settings and compares against floor(N*65536/F). The scenarios also cover the choice of source, rounding on a sync edge, the carry between the halves, and the routing of the flag to each output.

// File: rtl/aon_tmr_pkg.sv
package aon_tmr_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL    = 4'd0;
  localparam logic [ADDR_W-1:0] A_CLR     = 4'd1;
  localparam logic [ADDR_W-1:0] A_TIME0   = 4'd2;
  localparam logic [ADDR_W-1:0] A_ALARM0  = 4'd6;
  localparam logic [ADDR_W-1:0] A_FREQ0   = 4'd10;
  localparam logic [ADDR_W-1:0] A_TIME_LO = 4'd14;
  localparam logic [ADDR_W-1:0] A_TIME_HI = 4'd15;

  typedef enum logic [1:0] {
    SRC_LP   = 2'd0,
    SRC_XO   = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_NONE = 2'd3
  } src_e;

  typedef struct packed {
    src_e src;
    logic sync_en;
    logic pwrup_en;
    logic irq_en;
    logic alarm_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/aon_tmr_edge.sv
module aon_tmr_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      rise_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
      rise_o <= sync_q[STAGES-1] & ~prev_q;
    end
  end
endmodule

// File: rtl/aon_tmr_regs.sv
module aon_tmr_regs
  import aon_tmr_pkg::*;
#(
  parameter logic [15:0] PASSWORD = 16'h5A3C,
  parameter int          TW       = 64,
  parameter int          N_OSC    = 2,
  parameter int          FW       = 32,
  parameter int          USE_W    = 3,
  parameter logic [FW-1:0] LP_RST = 32'h0020_C49C,
  parameter logic [FW-1:0] XO_RST = 32'h2EE0_0000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [31:0]               wr_data,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [31:0]               rd_data,
  input  logic [TW-1:0]             count_i,
  input  logic [USE_W-1:0]          using_i,
  input  logic                      flag_i,
  output ctrl_t                     ctrl_o,
  output logic [TW-1:0]             alarm_o,
  output logic [N_OSC-1:0][FW-1:0]  freq_o,
  output logic                      tload_o,
  output logic [$clog2(TW/16)-1:0]  tidx_o,
  output logic [15:0]               tdata_o,
  output logic                      flag_clr_o
);
  localparam int N_SLICE = TW / 16;
  localparam int SLW     = $clog2(N_SLICE);

  logic        key_ok;
  logic        wr_ok;
  logic [15:0] payload;

  assign key_ok  = (wr_data[31:16] == PASSWORD);
  assign wr_ok   = wr_en && key_ok;
  assign payload = wr_data[15:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o     <= '0;
      alarm_o    <= '0;
      tload_o    <= 1'b0;
      tidx_o     <= '0;
      tdata_o    <= '0;
      flag_clr_o <= 1'b0;
      rd_data    <= '0;
      for (int g = 0; g < N_OSC; g++) freq_o[g] <= (g == 0) ? LP_RST : XO_RST;
    end else begin
      tload_o    <= 1'b0;
      flag_clr_o <= 1'b0;
      if (wr_ok) begin
        if (wr_addr == A_CTRL) ctrl_o <= ctrl_t'(payload[6:0]);
        if (wr_addr == A_CLR)  flag_clr_o <= payload[0];
        for (int s = 0; s < N_SLICE; s++) begin
          if (wr_addr == A_TIME0 + ADDR_W'(s)) begin
            tload_o <= 1'b1;
            tidx_o  <= SLW'(s);
            tdata_o <= payload;
          end
          if (wr_addr == A_ALARM0 + ADDR_W'(s) && !ctrl_o.alarm_en)
            alarm_o[s*16 +: 16] <= payload;
        end
        for (int g = 0; g < N_OSC; g++) begin
          if (wr_addr == A_FREQ0 + ADDR_W'(2*g))     freq_o[g][FW-1:16] <= payload;
          if (wr_addr == A_FREQ0 + ADDR_W'(2*g + 1)) freq_o[g][15:0]    <= payload;
        end
      end
      if (rd_en) begin
        rd_data <= '0;
        if (rd_addr == A_CTRL)
          rd_data <= {19'b0, flag_i, 1'b0, using_i, 1'b0, ctrl_o};
        if (rd_addr == A_TIME_LO) rd_data <= count_i[31:0];
        if (rd_addr == A_TIME_HI) rd_data <= count_i[63:32];
        for (int s = 0; s < N_SLICE; s++)
          if (rd_addr == A_ALARM0 + ADDR_W'(s)) rd_data <= {16'b0, alarm_o[s*16 +: 16]};
        for (int g = 0; g < N_OSC; g++) begin
          if (rd_addr == A_FREQ0 + ADDR_W'(2*g))     rd_data <= {16'b0, freq_o[g][FW-1:16]};
          if (rd_addr == A_FREQ0 + ADDR_W'(2*g + 1)) rd_data <= {16'b0, freq_o[g][15:0]};
        end
      end
    end
  end

  // R1: a write with a bad key disturbs no configuration
  assert_bad_key_ignored_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !key_ok) |=> ($stable(ctrl_o) && $stable(alarm_o) && $stable(freq_o)));

  // R10: armed alarm time cannot be rewritten
  assert_alarm_locked_R10: assert property (@(posedge clk) disable iff (rst)
    ctrl_o.alarm_en |=> $stable(alarm_o));
endmodule

// File: rtl/aon_tmr_tickgen.sv
module aon_tmr_tickgen
  import aon_tmr_pkg::*;
#(
  parameter int N_OSC     = 2,
  parameter int FW        = 32,
  parameter int FRW       = 16,
  parameter int SW_CYCLES = 4,
  parameter int USE_W     = N_OSC + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  src_e                     src_req_i,
  input  logic [N_OSC-1:0]         osc_pulse_i,
  input  logic                     ext_rise_i,
  input  logic [N_OSC-1:0][FW-1:0] freq_i,
  output logic                     tick_o,
  output logic [USE_W-1:0]         using_o
);
  localparam int AW   = FW + 1;
  localparam int SWCW = $clog2(SW_CYCLES + 1);
  localparam logic [AW-1:0] ONE_CYC = AW'(1) << FRW;

  src_e            act_q;
  logic [SWCW-1:0] sw_cnt_q;
  logic            settled;
  logic [N_OSC-1:0] hit_q;
  logic            ext_hit_q;

  assign settled = (src_req_i == act_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= SRC_NONE;
      sw_cnt_q <= '0;
      using_o  <= '0;
    end else begin
      if (!settled) begin
        if (sw_cnt_q == SWCW'(SW_CYCLES - 1)) begin
          act_q    <= src_req_i;
          sw_cnt_q <= '0;
        end else begin
          sw_cnt_q <= sw_cnt_q + 1'b1;
        end
      end else begin
        sw_cnt_q <= '0;
      end
      for (int k = 0; k < USE_W; k++)
        using_o[k] <= settled && (act_q == src_e'(k));
    end
  end

  for (genvar g = 0; g < N_OSC; g++) begin : g_osc
    logic [AW-1:0] acc_q;
    logic [AW-1:0] step;
    logic [AW-1:0] thresh;
    logic          active;

    assign active = settled && (act_q == src_e'(g));
    assign step   = acc_q + ONE_CYC;
    assign thresh = {1'b0, freq_i[g]};

    always_ff @(posedge clk) begin
      if (rst || !active) begin
        acc_q    <= '0;
        hit_q[g] <= 1'b0;
      end else if (osc_pulse_i[g]) begin
        if (step >= thresh) begin
          acc_q    <= step - thresh;
          hit_q[g] <= 1'b1;
        end else begin
          acc_q    <= step;
          hit_q[g] <= 1'b0;
        end
      end else begin
        hit_q[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ext_hit_q <= 1'b0;
    else     ext_hit_q <= ext_rise_i && settled && (act_q == SRC_EXT);
  end

  assign tick_o = ext_hit_q | (|hit_q);

  // R5: never more than one source reported in use
  assert_using_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(using_o));

  // R4: a tick is only produced by a source that has finished switching
  assert_tick_after_switch_R4: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $past(settled));
endmodule

// File: rtl/aon_tmr_counter.sv
module aon_tmr_counter #(
  parameter int TW         = 64,
  parameter int MS_PER_SEC = 1000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick_i,
  input  logic                     run_i,
  input  logic                     tload_i,
  input  logic [$clog2(TW/16)-1:0] tidx_i,
  input  logic [15:0]              tdata_i,
  input  logic                     sync_rise_i,
  input  logic                     sync_en_i,
  input  logic [TW-1:0]            alarm_i,
  input  logic                     alarm_en_i,
  input  logic                     irq_en_i,
  input  logic                     pwrup_en_i,
  input  logic                     flag_clr_i,
  output logic [TW-1:0]            count_o,
  output logic                     flag_o,
  output logic                     irq_o,
  output logic                     pwrup_o
);
  localparam int PW = $clog2(MS_PER_SEC);

  logic [PW-1:0] phase_q;
  logic          sync_hit;
  logic [TW-1:0] round_step;
  logic          match;

  assign sync_hit   = run_i && sync_en_i && sync_rise_i;
  assign round_step = TW'(MS_PER_SEC) - TW'(phase_q);
  assign match      = alarm_en_i && (count_o == alarm_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
      phase_q <= '0;
    end else if (tload_i) begin
      count_o[tidx_i*16 +: 16] <= tdata_i;
      phase_q <= '0;
    end else if (sync_hit) begin
      if (phase_q != '0) count_o <= count_o + round_step;
      phase_q <= '0;
    end else if (run_i && tick_i) begin
      count_o <= count_o + 1'b1;
      phase_q <= (phase_q == PW'(MS_PER_SEC - 1)) ? '0 : phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o  <= 1'b0;
      irq_o   <= 1'b0;
      pwrup_o <= 1'b0;
    end else begin
      if (match)           flag_o <= 1'b1;
      else if (flag_clr_i) flag_o <= 1'b0;
      irq_o   <= flag_o && irq_en_i;
      pwrup_o <= flag_o && pwrup_en_i;
    end
  end

  // R7: outside loads and syncs the count moves by at most one
  assert_single_step_R7: assert property (@(posedge clk) disable iff (rst)
    (!tload_i && !sync_hit) |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1));

  // R8: sub-second phase stays inside one second
  assert_phase_range_R8: assert property (@(posedge clk) disable iff (rst)
    phase_q < PW'(MS_PER_SEC));

  // R9: flag only rises after an armed match
  assert_flag_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past(alarm_en_i && count_o == alarm_i));
endmodule

// File: rtl/aon_ms_timer.sv
module aon_ms_timer
  import aon_tmr_pkg::*;
#(
  parameter logic [15:0] PASSWORD   = 16'h5A3C,
  parameter int          TW         = 64,
  parameter int          N_OSC      = 2,
  parameter int          FW         = 32,
  parameter int          SW_CYCLES  = 4,
  parameter int          MS_PER_SEC = 1000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic [3:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        lp_ref_pulse,
  input  logic        xo_ref_pulse,
  input  logic        ext_khz_pin,
  input  logic        ext_hz_pin,
  output logic        alarm_irq,
  output logic        pwrup_req
);
  localparam int USE_W = N_OSC + 1;
  localparam int SLW   = $clog2(TW / 16);

  ctrl_t                    ctrl;
  logic [TW-1:0]            alarm;
  logic [N_OSC-1:0][FW-1:0] freq;
  logic                     tload;
  logic [SLW-1:0]           tidx;
  logic [15:0]              tdata;
  logic                     flag_clr;
  logic [TW-1:0]            count;
  logic [USE_W-1:0]         using_src;
  logic                     flag;
  logic                     tick;
  logic                     khz_rise;
  logic                     hz_rise;

  aon_tmr_regs #(
    .PASSWORD(PASSWORD), .TW(TW), .N_OSC(N_OSC), .FW(FW), .USE_W(USE_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .count_i(count), .using_i(using_src), .flag_i(flag),
    .ctrl_o(ctrl), .alarm_o(alarm), .freq_o(freq),
    .tload_o(tload), .tidx_o(tidx), .tdata_o(tdata), .flag_clr_o(flag_clr)
  );

  aon_tmr_edge #(.STAGES(SYNC_STAGES)) u_khz_edge (
    .clk(clk), .rst(rst), .pin_i(ext_khz_pin), .rise_o(khz_rise)
  );

  aon_tmr_edge #(.STAGES(SYNC_STAGES)) u_hz_edge (
    .clk(clk), .rst(rst), .pin_i(ext_hz_pin), .rise_o(hz_rise)
  );

  aon_tmr_tickgen #(
    .N_OSC(N_OSC), .FW(FW), .SW_CYCLES(SW_CYCLES), .USE_W(USE_W)
  ) u_tickgen (
    .clk(clk), .rst(rst), .src_req_i(ctrl.src),
    .osc_pulse_i({xo_ref_pulse, lp_ref_pulse}), .ext_rise_i(khz_rise),
    .freq_i(freq), .tick_o(tick), .using_o(using_src)
  );

  aon_tmr_counter #(.TW(TW), .MS_PER_SEC(MS_PER_SEC)) u_counter (
    .clk(clk), .rst(rst), .tick_i(tick), .run_i(ctrl.run),
    .tload_i(tload), .tidx_i(tidx), .tdata_i(tdata),
    .sync_rise_i(hz_rise), .sync_en_i(ctrl.sync_en),
    .alarm_i(alarm), .alarm_en_i(ctrl.alarm_en),
    .irq_en_i(ctrl.irq_en), .pwrup_en_i(ctrl.pwrup_en), .flag_clr_i(flag_clr),
    .count_o(count), .flag_o(flag), .irq_o(alarm_irq), .pwrup_o(pwrup_req)
  );
endmodule

// File: tb/aon_ms_timer_tb.sv
`timescale 1ns/1ps
module aon_ms_timer_tb;
  localparam logic [15:0] KEY = 16'h5A3C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        lp_ref_pulse = 1'b0;
  logic        xo_ref_pulse = 1'b0;
  logic        ext_khz_pin = 1'b0;
  logic        ext_hz_pin = 1'b0;
  logic        alarm_irq;
  logic        pwrup_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  aon_ms_timer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .lp_ref_pulse(lp_ref_pulse), .xo_ref_pulse(xo_ref_pulse),
    .ext_khz_pin(ext_khz_pin), .ext_hz_pin(ext_hz_pin),
    .alarm_irq(alarm_irq), .pwrup_req(pwrup_req)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_raw(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_raw(a, {KEY, d});
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd_time(output logic [63:0] t);
    logic [31:0] lo, hi;
    rd(4'd14, lo);
    rd(4'd15, hi);
    t = {hi, lo};
  endtask

  task automatic load_time(input logic [63:0] t);
    for (int s = 0; s < 4; s++) wr(4'(2 + s), t[s*16 +: 16]);
    idle(3);
  endtask

  task automatic lp_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) lp_ref_pulse = 1'b1;
      @(negedge clk) lp_ref_pulse = 1'b0;
    end
    idle(6);
  endtask

  function automatic logic [15:0] ctrlw(input logic [1:0] src, input logic sync_en,
                                        input logic pw, input logic ie,
                                        input logic ae, input logic run);
    return {9'b0, src, sync_en, pw, ie, ae, run};
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [63:0] t;
    logic [63:0] exp;
    idle(4);
    rst = 1'b0;
    idle(12);

    // R12: reset state, low-power source settled in
    rd(4'd0, r);
    chk("R12 ctrl after reset", r, 32'h100);
    rd_time(t);
    chk("R12 count after reset", t, 0);
    chk("R12 outputs after reset", {alarm_irq, pwrup_req}, 0);

    // R3: sweep of integer and fraction settings
    for (int ii = 1; ii <= 3; ii++) begin
      for (int ff = 0; ff < 4; ff++) begin
        wr(4'd10, 16'(ii));
        wr(4'd11, 16'(ff * 16384));
        wr(4'd0, ctrlw(2'd3, 0, 0, 0, 0, 1));
        idle(10);
        wr(4'd0, ctrlw(2'd0, 0, 0, 0, 0, 1));
        idle(10);
        load_time(64'd0);
        lp_pulses(37);
        rd_time(t);
        exp = (64'd37 * 64'd65536) / (64'(ii) * 64'd65536 + 64'(ff) * 64'd16384);
        chk($sformatf("R3 fractional rate int=%0d frac=%0d", ii, ff * 16384), t, exp);
      end
    end

    // R4 / R5: crystal source with a switch handshake; LP strobes ignored
    wr(4'd12, 16'd2);
    wr(4'd13, 16'd0);
    wr(4'd0, ctrlw(2'd1, 0, 0, 0, 0, 1));
    idle(1);
    rd(4'd0, r);
    chk("R5 in-use flags clear while switching", r[10:8], 3'b000);
    idle(10);
    rd(4'd0, r);
    chk("R5 crystal in use after switch", r[10:8], 3'b010);
    load_time(64'd0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk) begin lp_ref_pulse = 1'b1; xo_ref_pulse = 1'b1; end
      @(negedge clk) begin lp_ref_pulse = 1'b0; xo_ref_pulse = 1'b0; end
    end
    idle(6);
    rd_time(t);
    chk("R4 only crystal strobes count", t, 5);

    // R6: external 1 kHz pin
    wr(4'd0, ctrlw(2'd2, 0, 0, 0, 0, 1));
    idle(10);
    rd(4'd0, r);
    chk("R5 external pin in use", r[10:8], 3'b100);
    load_time(64'd0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) ext_khz_pin = 1'b1;
      lp_ref_pulse = 1'b1;
      @(negedge clk) lp_ref_pulse = 1'b0;
      idle(4);
      ext_khz_pin = 1'b0;
      idle(5);
    end
    idle(6);
    rd_time(t);
    chk("R6 external edges counted", t, 6);

    // back to LP with one tick per strobe
    wr(4'd10, 16'd1);
    wr(4'd11, 16'd0);
    wr(4'd0, ctrlw(2'd3, 0, 0, 0, 0, 1));
    idle(10);
    wr(4'd0, ctrlw(2'd0, 0, 0, 0, 0, 1));
    idle(10);

    // R2: slice load and carry into the upper half
    load_time(64'h0000_0000_FFFF_FFFE);
    rd_time(t);
    chk("R2 loaded value", t, 64'h0000_0000_FFFF_FFFE);
    lp_pulses(3);
    rd_time(t);
    chk("R2 carry between halves", t, 64'h0000_0001_0000_0001);
    load_time(64'h1234_5678_9ABC_DEF0);
    rd_time(t);
    chk("R2 four-slice load", t, 64'h1234_5678_9ABC_DEF0);

    // R7: run clear holds the count
    wr(4'd0, ctrlw(2'd0, 0, 0, 0, 0, 0));
    load_time(64'd50);
    lp_pulses(5);
    rd_time(t);
    chk("R7 count holds with run clear", t, 50);
    wr(4'd0, ctrlw(2'd0, 0, 0, 0, 0, 1));
    idle(2);

    // R1: wrong key writes ignored
    wr_raw(4'd2, {16'h1234, 16'h7777});
    idle(3);
    rd_time(t);
    chk("R1 bad-key time write ignored", t, 50);
    wr_raw(4'd0, {16'h0000, 16'h0000});
    idle(2);
    rd(4'd0, r);
    chk("R1 bad-key control write ignored", r[6:0], 7'h01);

    // R8: 1 Hz rounding
    wr(4'd0, ctrlw(2'd0, 1, 0, 0, 0, 1));
    load_time(64'd5000);
    lp_pulses(7);
    @(negedge clk) ext_hz_pin = 1'b1;
    idle(8);
    rd_time(t);
    chk("R8 sync rounds up", t, 6000);
    ext_hz_pin = 1'b0;
    idle(8);
    load_time(64'd7000);
    ext_hz_pin = 1'b1;
    idle(8);
    rd_time(t);
    chk("R8 sync on boundary unchanged", t, 7000);
    ext_hz_pin = 1'b0;
    idle(8);

    // R9 / R10 / R11: alarm with interrupt routing
    wr(4'd0, ctrlw(2'd0, 0, 0, 0, 0, 1));
    wr(4'd6, 16'h0105);
    for (int s = 1; s < 4; s++) wr(4'(6 + s), 16'h0000);
    load_time(64'h100);
    wr(4'd0, ctrlw(2'd0, 0, 0, 1, 1, 1));
    lp_pulses(4);
    rd(4'd0, r);
    chk("R9 no flag before match", r[12], 1'b0);
    chk("R11 irq low before match", alarm_irq, 1'b0);
    lp_pulses(1);
    rd(4'd0, r);
    chk("R9 flag on match", r[12], 1'b1);
    chk("R11 irq routed", alarm_irq, 1'b1);
    chk("R11 pwrup not routed", pwrup_req, 1'b0);
    wr(4'd6, 16'h0200);
    rd(4'd6, r);
    chk("R10 armed alarm write ignored", r, 32'h0105);
    lp_pulses(1);
    rd(4'd0, r);
    chk("R9 flag sticky past match", r[12], 1'b1);
    wr(4'd1, 16'h0001);
    idle(3);
    rd(4'd0, r);
    chk("R9 flag cleared by W1C", r[12], 1'b0);
    chk("R11 irq follows clear", alarm_irq, 1'b0);

    // R11: power-up routing
    wr(4'd0, ctrlw(2'd0, 0, 0, 0, 0, 1));
    wr(4'd6, 16'h010A);
    rd(4'd6, r);
    chk("R10 disarmed alarm write taken", r, 32'h010A);
    wr(4'd0, ctrlw(2'd0, 0, 1, 0, 1, 1));
    lp_pulses(4);
    chk("R11 pwrup routed", pwrup_req, 1'b1);
    chk("R11 irq not routed", alarm_irq, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule